// File: doc/BRIEF.md
# Byte Pointer Adjust Unit

This unit moves a 36-bit byte pointer forward or backward by a signed byte count, as when a program steps through packed characters in memory. It accepts two pointer layouts: a local form with a 6-bit position field, a 6-bit size field and an 18-bit address, and a compact form in which a single 6-bit code selects both the byte size and the byte slot, beside a 30-bit address.

Each request starts with a one-cycle `start` pulse carrying the pointer and the count. The unit first works out how many whole bytes fit in a word and where the current byte sits among them. It then divides the count, taken relative to the first byte of the word, by that capacity. The quotient is the number of words to move and the remainder is the byte slot in the target word. The quotient is rounded toward minus infinity, so backward moves land on the right word. Capacity counting, the division and the rebuilding of the position field each run over several cycles. `done` pulses for one cycle when `ptr_out` and the two flags are valid, and they hold until the next request.

Top module: `byte_ptr_adjust`

## Requirements
- R1: Bits 35:30 of the pointer form the leading field. A value of 36 or less marks the local form: size in bits 29:24, spare bits 23:18, address in bits 17:0. A value of 37 to 63 marks the compact form, with the code in bits 35:30 and the address in bits 29:0.
- R2: For a local pointer with position P and size S, the capacity is floor(P/S) + floor((36-P)/S), found by repeated subtraction of S. A capacity of zero sets `no_fit` and returns the pointer unchanged.
- R3: A local pointer with S = 0 is returned unchanged, with both flags low.
- R4: The count is taken relative to the first byte of the word. The modified count is count + floor((36-P)/S) - 1 for a local pointer and count + code - base - 1 for a compact one. Quotient q and remainder r satisfy m = q*cap + r with 0 <= r < cap. The quotient is added modulo 2^18 to a local address and modulo 2^30 to a compact address.
- R5: For a negative modified count, the magnitude is divided first. With a nonzero magnitude remainder, q is the ones complement of the magnitude quotient and r is the capacity minus that remainder. With a zero remainder, q is the negated magnitude quotient and r is 0.
- R6: The new local position is 36 - g - (r+1)*S, where g = (36-P) mod S. It is reached by stepping down S once more than the remainder. Size, spare bits and bits 35:18 other than the position are kept.
- R7: Compact groups have base codes and capacities 37/6 (size 6), 44/4 (size 8), 49/5 (size 7), 55/4 (size 9) and 60/2 (size 18). Codes 38..43, 45..48, 50..54, 56..59 and 61..62 name bytes. The new code is base + 1 + r.
- R8: Code 63 is illegal. It sets `bad_code` and returns the pointer unchanged.
- R9: The division runs 7 steps when the modified count's magnitude is below 64, 19 when it is below 2^18, and 36 otherwise. For the same pointer and remainder, a 36-step request takes exactly 29 cycles longer than a 7-step one.
- R10: After reset `done`, both flags and `ptr_out` are 0. `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request pulse, taken while idle |
| ptr_in | input | 36 | Pointer to adjust |
| count_in | input | 36 | Signed byte count, two's complement |
| done | output | 1 | One-cycle pulse, result valid |
| ptr_out | output | 36 | Adjusted pointer |
| no_fit | output | 1 | Local size leaves no whole byte in a word |
| bad_code | output | 1 | Compact code 63 was given |

## Verification
Local pointers are driven with aligned sizes (6, 8) and with a size of 7, which leaves a gap. The gap separates the top-down position rebuild from a plain multiply of the slot index. Negative counts that land on a word boundary and counts that land inside a word separate the negated quotient from the complemented one. Counts large enough to cross many words, and addresses at the top or bottom of their field, expose a wrong carry width. Compact pointers are taken from every size group, including the base codes and the last code of each group, to pin down the group table. A pair of requests with equal pointer and remainder but very different count magnitudes shows the shortened division by its latency alone.

// File: rtl/bpa_pkg.sv
`timescale 1ns/1ps
// Shared constants, group decode and state types for the byte pointer
// adjust unit. Assumes a 36-bit word with 6-bit position/size fields.
package bpa_pkg;
    localparam int BPA_WORD_W    = 36;
    localparam int BPA_FIELD_W   = 6;
    localparam int BPA_LADDR_W   = 18;
    localparam int BPA_GADDR_W   = 30;
    localparam int BPA_LOCAL_MAX = 36;
    localparam int BPA_BAD_CODE  = 63;

    typedef struct packed {
        logic                   legal;
        logic [BPA_FIELD_W-1:0] cap;
        logic [BPA_FIELD_W-1:0] base;
    } grp_t;

    // Map a compact code to its group capacity and base code.
    function automatic grp_t grp_lookup(input logic [BPA_FIELD_W-1:0] code);
        grp_t g;
        g.legal = 1'b1;
        if (code <= 6'd43) begin
            g.cap = 6'd6;  g.base = 6'd37;
        end else if (code <= 6'd48) begin
            g.cap = 6'd4;  g.base = 6'd44;
        end else if (code <= 6'd54) begin
            g.cap = 6'd5;  g.base = 6'd49;
        end else if (code <= 6'd59) begin
            g.cap = 6'd4;  g.base = 6'd55;
        end else if (code <= 6'd62) begin
            g.cap = 6'd2;  g.base = 6'd60;
        end else begin
            g.legal = 1'b0; g.cap = '0; g.base = '0;
        end
        return g;
    endfunction

    typedef enum logic [2:0] {
        T_IDLE, T_COUNT, T_DIV, T_STEP, T_FIN
    } top_state_t;

    typedef enum logic [1:0] {
        C_IDLE, C_RIGHT, C_LEFT
    } cnt_state_t;

    typedef enum logic [1:0] {
        D_IDLE, D_RUN, D_FIX
    } div_state_t;
endpackage

// File: rtl/bpa_grp_decode.sv
`timescale 1ns/1ps
// Combinational decode of the leading pointer field: tells the local form
// from the compact form and, for compact codes, gives capacity, base and
// the signed index of the current byte (code - base - 1, -1 for the base).
// Assumes codes above LOCAL_MAX are compact.
module bpa_grp_decode
    import bpa_pkg::*;
#(
    parameter int FIELD_W   = BPA_FIELD_W,
    parameter int LOCAL_MAX = BPA_LOCAL_MAX
) (
    input  logic [FIELD_W-1:0] code,
    output logic               compact,
    output logic               legal,
    output logic [FIELD_W-1:0] cap,
    output logic [FIELD_W-1:0] base,
    output logic [FIELD_W:0]   cur_idx
);
    localparam logic [FIELD_W-1:0] LMAX = FIELD_W'(LOCAL_MAX);
    localparam logic [FIELD_W:0]   ONE  = (FIELD_W+1)'(1);

    grp_t g;

    // Table lookup and index of the current byte within its word.
    always_comb begin
        g       = grp_lookup(code);
        compact = code > LMAX;
        legal   = g.legal;
        cap     = g.cap;
        base    = g.base;
        cur_idx = {1'b0, code} - {1'b0, g.base} - ONE;
    end
endmodule

// File: rtl/bpa_capcount.sv
`timescale 1ns/1ps
// Iterative byte capacity counter for a local pointer. Counts the whole
// bytes below the current position, then those at or above it, one
// subtraction of the size per cycle. Also returns the gap left above the
// highest byte. Assumes size is nonzero and pos is at most WORD_BITS.
module bpa_capcount
    import bpa_pkg::*;
#(
    parameter int FIELD_W   = BPA_FIELD_W,
    parameter int WORD_BITS = BPA_LOCAL_MAX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] pos,
    input  logic [FIELD_W-1:0] size,
    output logic               done,
    output logic [FIELD_W-1:0] right_cnt,
    output logic [FIELD_W-1:0] left_cnt,
    output logic [FIELD_W-1:0] gap
);
    localparam logic [FIELD_W-1:0] SPAN = FIELD_W'(WORD_BITS);
    localparam logic [FIELD_W-1:0] ONE  = FIELD_W'(1);
    localparam int PW = 2 * FIELD_W;

    cnt_state_t         state;
    logic [FIELD_W-1:0] pos_q, size_q, acc_q, rc_q, lc_q, gap_q;
    logic               done_q;

    // Two counting phases, one subtraction of the size per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= C_IDLE;
            pos_q  <= '0;
            size_q <= '0;
            acc_q  <= '0;
            rc_q   <= '0;
            lc_q   <= '0;
            gap_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                C_IDLE: if (start) begin
                    pos_q  <= pos;
                    size_q <= size;
                    acc_q  <= pos;
                    rc_q   <= '0;
                    lc_q   <= '0;
                    state  <= C_RIGHT;
                end
                C_RIGHT: if (acc_q >= size_q) begin
                    acc_q <= acc_q - size_q;
                    rc_q  <= rc_q + ONE;
                end else begin
                    acc_q <= SPAN - pos_q;
                    state <= C_LEFT;
                end
                C_LEFT: if (acc_q >= size_q) begin
                    acc_q <= acc_q - size_q;
                    lc_q  <= lc_q + ONE;
                end else begin
                    gap_q  <= acc_q;
                    done_q <= 1'b1;
                    state  <= C_IDLE;
                end
                default: state <= C_IDLE;
            endcase
        end
    end

    assign done      = done_q;
    assign right_cnt = rc_q;
    assign left_cnt  = lc_q;
    assign gap       = gap_q;

    // R2
    size_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> size != '0);
    // R2
    right_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (PW'(rc_q) * PW'(size_q) <= PW'(pos_q)) &&
                   (PW'(pos_q) - PW'(rc_q) * PW'(size_q) < PW'(size_q)));
    // R2
    left_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (PW'(lc_q) * PW'(size_q) + PW'(gap_q) == PW'(SPAN - pos_q)) &&
                   (gap_q < size_q));
endmodule

// File: rtl/bpa_divider.sv
`timescale 1ns/1ps
// Iterative signed-by-unsigned restoring divider with floor rounding.
// The magnitude of the dividend is divided one quotient bit per cycle.
// The step count is shortened for small magnitudes. A final cycle applies
// the sign: the quotient is negated, or ones-complemented with the
// remainder offset by the divisor. Assumes a nonzero divisor.
module bpa_divider
    import bpa_pkg::*;
#(
    parameter int DW         = BPA_WORD_W,
    parameter int NW         = BPA_FIELD_W,
    parameter int SMALL_BITS = 6,
    parameter int MID_BITS   = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [NW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quo,
    output logic [NW-1:0] rem
);
    localparam int CW          = $clog2(DW + 1);
    localparam int SMALL_STEPS = SMALL_BITS + 1;
    localparam int MID_STEPS   = MID_BITS + 1;
    localparam logic [DW-1:0] SMALL_LIM = DW'(1) << SMALL_BITS;
    localparam logic [DW-1:0] MID_LIM   = DW'(1) << MID_BITS;
    localparam logic [CW-1:0] ONE_C     = CW'(1);

    div_state_t    state;
    logic [DW-1:0] mag, shreg_q, quo_q;
    logic [NW-1:0] part_q, dvs_q, rem_q, part_n;
    logic [NW:0]   trial;
    logic [CW-1:0] steps, cnt_q;
    logic          neg_q, take, done_q;

    // Magnitude of the dividend and the step count it needs.
    always_comb begin
        mag = dividend[DW-1] ? (DW'(0) - dividend) : dividend;
        if (mag < SMALL_LIM)    steps = CW'(SMALL_STEPS);
        else if (mag < MID_LIM) steps = CW'(MID_STEPS);
        else                    steps = CW'(DW);
    end

    // One restoring step: shift in a dividend bit, subtract if it fits.
    always_comb begin
        trial  = {part_q, shreg_q[DW-1]};
        take   = trial >= {1'b0, dvs_q};
        part_n = take ? NW'(trial - {1'b0, dvs_q}) : trial[NW-1:0];
    end

    // Load, iterate, then apply the floor correction for a negative sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= D_IDLE;
            shreg_q <= '0;
            part_q  <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            neg_q   <= 1'b0;
            quo_q   <= '0;
            rem_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                D_IDLE: if (start) begin
                    shreg_q <= mag << (CW'(DW) - steps);
                    part_q  <= '0;
                    dvs_q   <= divisor;
                    neg_q   <= dividend[DW-1];
                    cnt_q   <= steps;
                    state   <= D_RUN;
                end
                D_RUN: begin
                    shreg_q <= {shreg_q[DW-2:0], take};
                    part_q  <= part_n;
                    cnt_q   <= cnt_q - ONE_C;
                    if (cnt_q == ONE_C) state <= D_FIX;
                end
                D_FIX: begin
                    done_q <= 1'b1;
                    state  <= D_IDLE;
                    if (!neg_q) begin
                        quo_q <= shreg_q;
                        rem_q <= part_q;
                    end else if (part_q == '0) begin
                        quo_q <= DW'(0) - shreg_q;
                        rem_q <= '0;
                    end else begin
                        quo_q <= ~shreg_q;
                        rem_q <= dvs_q - part_q;
                    end
                end
                default: state <= D_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
    assign rem  = rem_q;

    // R2
    divisor_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> divisor != '0);
    // R4
    rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> rem_q < dvs_q);
    // R5
    neg_quotient_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && neg_q && rem_q != '0 |-> quo_q[DW-1]);
endmodule

// File: rtl/byte_ptr_adjust.sv
`timescale 1ns/1ps
// Byte pointer adjust unit. Takes a 36-bit pointer in local or compact
// form and a signed count. Finds the word capacity and the current byte
// index, divides the relative count by the capacity with floor rounding,
// and rebuilds the pointer. Sequencing: IDLE -> (COUNT) -> DIV -> (STEP)
// -> FIN, with one done pulse in the cycle after FIN. Assumes start is
// only pulsed while no request is in flight.
module byte_ptr_adjust
    import bpa_pkg::*;
#(
    parameter int WORD_W  = BPA_WORD_W,
    parameter int FIELD_W = BPA_FIELD_W,
    parameter int LADDR_W = BPA_LADDR_W,
    parameter int GADDR_W = BPA_GADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] ptr_in,
    input  logic [WORD_W-1:0] count_in,
    output logic              done,
    output logic [WORD_W-1:0] ptr_out,
    output logic              no_fit,
    output logic              bad_code
);
    localparam int P_MSB = WORD_W - 1;
    localparam int S_MSB = WORD_W - FIELD_W - 1;
    localparam int M_MSB = WORD_W - 2 * FIELD_W - 1;
    localparam logic [FIELD_W-1:0] ONE_F = FIELD_W'(1);
    localparam logic [FIELD_W-1:0] SPAN  = FIELD_W'(BPA_LOCAL_MAX);
    localparam logic [FIELD_W-1:0] BAD   = FIELD_W'(BPA_BAD_CODE);
    localparam logic [WORD_W-1:0]  ONE_W = WORD_W'(1);

    top_state_t        state;
    logic [WORD_W-1:0] ptr_q, adj_q, res_q;
    logic              compact_q, nofit_q, bad_q, done_q;
    logic [FIELD_W-1:0] p_acc, step_cnt;

    logic [FIELD_W-1:0] in_p, in_s, s_q, dec_code;
    logic               dec_compact, dec_legal;
    logic [FIELD_W-1:0] dec_cap, dec_base;
    logic [FIELD_W:0]   dec_cur;

    logic               cc_start, cc_done;
    logic [FIELD_W-1:0] cc_right, cc_left, cc_gap, loc_cap;

    logic               dv_start, dv_done;
    logic [WORD_W-1:0]  dv_dividend, dv_quo;
    logic [FIELD_W-1:0] dv_divisor, dv_rem;

    // Field views of the incoming and the captured pointer.
    always_comb begin
        in_p     = ptr_in[P_MSB -: FIELD_W];
        in_s     = ptr_in[S_MSB -: FIELD_W];
        s_q      = ptr_q[S_MSB -: FIELD_W];
        dec_code = (state == T_IDLE) ? in_p : ptr_q[P_MSB -: FIELD_W];
        loc_cap  = cc_right + cc_left;
    end

    bpa_grp_decode #(
        .FIELD_W   (FIELD_W),
        .LOCAL_MAX (BPA_LOCAL_MAX)
    ) u_dec (
        .code    (dec_code),
        .compact (dec_compact),
        .legal   (dec_legal),
        .cap     (dec_cap),
        .base    (dec_base),
        .cur_idx (dec_cur)
    );

    // Start conditions and operands for the counter and the divider.
    always_comb begin
        cc_start = (state == T_IDLE) && start && !dec_compact && (in_s != '0);
        dv_start = ((state == T_IDLE) && start && dec_compact && dec_legal) ||
                   ((state == T_COUNT) && cc_done && (loc_cap != '0));
        if (state == T_IDLE) begin
            dv_dividend = count_in + {{(WORD_W-FIELD_W-1){dec_cur[FIELD_W]}}, dec_cur};
            dv_divisor  = dec_cap;
        end else begin
            dv_dividend = adj_q + {{(WORD_W-FIELD_W){1'b0}}, cc_left} - ONE_W;
            dv_divisor  = loc_cap;
        end
    end

    bpa_capcount #(
        .FIELD_W   (FIELD_W),
        .WORD_BITS (BPA_LOCAL_MAX)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cc_start),
        .pos       (in_p),
        .size      (in_s),
        .done      (cc_done),
        .right_cnt (cc_right),
        .left_cnt  (cc_left),
        .gap       (cc_gap)
    );

    bpa_divider #(
        .DW         (WORD_W),
        .NW         (FIELD_W),
        .SMALL_BITS (6),
        .MID_BITS   (LADDR_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dv_start),
        .dividend (dv_dividend),
        .divisor  (dv_divisor),
        .done     (dv_done),
        .quo      (dv_quo),
        .rem      (dv_rem)
    );

    // Request sequencing and result assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= T_IDLE;
            ptr_q     <= '0;
            adj_q     <= '0;
            res_q     <= '0;
            compact_q <= 1'b0;
            nofit_q   <= 1'b0;
            bad_q     <= 1'b0;
            done_q    <= 1'b0;
            p_acc     <= '0;
            step_cnt  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                T_IDLE: if (start) begin
                    ptr_q     <= ptr_in;
                    adj_q     <= count_in;
                    compact_q <= dec_compact;
                    nofit_q   <= 1'b0;
                    bad_q     <= 1'b0;
                    if (dec_compact && !dec_legal) begin
                        res_q <= ptr_in;
                        bad_q <= 1'b1;
                        state <= T_FIN;
                    end else if (dec_compact) begin
                        state <= T_DIV;
                    end else if (in_s == '0) begin
                        res_q <= ptr_in;
                        state <= T_FIN;
                    end else begin
                        state <= T_COUNT;
                    end
                end
                T_COUNT: if (cc_done) begin
                    if (loc_cap == '0) begin
                        res_q   <= ptr_q;
                        nofit_q <= 1'b1;
                        state   <= T_FIN;
                    end else begin
                        state <= T_DIV;
                    end
                end
                T_DIV: if (dv_done) begin
                    if (compact_q) begin
                        res_q <= {dec_base + ONE_F + dv_rem,
                                  ptr_q[GADDR_W-1:0] + dv_quo[GADDR_W-1:0]};
                        state <= T_FIN;
                    end else begin
                        res_q <= {ptr_q[WORD_W-1:LADDR_W],
                                  ptr_q[LADDR_W-1:0] + dv_quo[LADDR_W-1:0]};
                        p_acc    <= SPAN - cc_gap;
                        step_cnt <= dv_rem + ONE_F;
                        state    <= T_STEP;
                    end
                end
                T_STEP: begin
                    p_acc    <= p_acc - s_q;
                    step_cnt <= step_cnt - ONE_F;
                    if (step_cnt == ONE_F) begin
                        res_q[P_MSB -: FIELD_W] <= p_acc - s_q;
                        state <= T_FIN;
                    end
                end
                T_FIN: begin
                    done_q <= 1'b1;
                    state  <= T_IDLE;
                end
                default: state <= T_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign ptr_out  = res_q;
    assign no_fit   = nofit_q;
    assign bad_code = bad_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R2
    nofit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && nofit_q |-> res_q == ptr_q && !compact_q);
    // R8
    badcode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && bad_q |-> res_q == ptr_q && ptr_q[P_MSB -: FIELD_W] == BAD && !nofit_q);
    // R6
    local_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !compact_q && !nofit_q |->
            res_q[S_MSB -: FIELD_W] == ptr_q[S_MSB -: FIELD_W] &&
            res_q[M_MSB:LADDR_W] == ptr_q[M_MSB:LADDR_W] &&
            res_q[P_MSB -: FIELD_W] <= SPAN);
    // R7
    compact_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && compact_q && !bad_q |->
            res_q[P_MSB -: FIELD_W] > SPAN && res_q[P_MSB -: FIELD_W] != BAD);
endmodule

// File: tb/sim_byte_ptr_adjust.sv
`timescale 1ns/1ps
module sim_byte_ptr_adjust;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [35:0] ptr_in = '0;
    logic [35:0] count_in = '0;
    logic        done, no_fit, bad_code;
    logic [35:0] ptr_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    byte_ptr_adjust u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ptr_in(ptr_in),
        .count_in(count_in), .done(done), .ptr_out(ptr_out),
        .no_fit(no_fit), .bad_code(bad_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] mk_local(input int p, input int s, input int mid, input int addr);
        return {6'(p), 6'(s), 6'(mid), 18'(addr)};
    endfunction

    function automatic logic [35:0] mk_comp(input int code, input int addr);
        return {6'(code), 30'(addr)};
    endfunction

    // Expected result from the requirements, using plain arithmetic.
    function automatic void model(input logic [35:0] p, input logic [35:0] c,
                                  output logic [35:0] r, output bit nf, output bit bd);
        longint m, q, rr, cap, base, cnt, cur;
        int P, S, left, right, g, code;
        logic [63:0] qv;
        cnt = longint'($signed(c));
        nf = 0; bd = 0; r = p;
        code = int'(p[35:30]);
        if (code <= 36) begin
            P = code; S = int'(p[29:24]);
            if (S == 0) return;
            right = P / S; left = (36 - P) / S; g = (36 - P) % S;
            cap = right + left;
            if (cap == 0) begin nf = 1; return; end
            m = cnt + left - 1;
            q = m / cap; rr = m % cap;
            if (rr < 0) begin rr += cap; q -= 1; end
            qv = 64'(q);
            r[17:0]  = p[17:0] + qv[17:0];
            r[35:30] = 6'(36 - g - (rr + 1) * S);
        end else begin
            if (code == 63) begin bd = 1; return; end
            if (code <= 43)      begin base = 37; cap = 6; end
            else if (code <= 48) begin base = 44; cap = 4; end
            else if (code <= 54) begin base = 49; cap = 5; end
            else if (code <= 59) begin base = 55; cap = 4; end
            else                 begin base = 60; cap = 2; end
            cur = code - base - 1;
            m = cnt + cur;
            q = m / cap; rr = m % cap;
            if (rr < 0) begin rr += cap; q -= 1; end
            qv = 64'(q);
            r[29:0]  = p[29:0] + qv[29:0];
            r[35:30] = 6'(base + 1 + rr);
        end
    endfunction

    // Issue one request, wait for done, compare against the model.
    task automatic run_case(input logic [35:0] p, input logic [35:0] c,
                            input string req, output int lat);
        logic [35:0] exp_r;
        bit exp_nf, exp_bd;
        model(p, c, exp_r, exp_nf, exp_bd);
        @(negedge clk);
        start = 1'b1; ptr_in = p; count_in = c;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        if (!done) begin
            check(1'b0, req, "done timeout", 36'(lat), 36'd0);
            return;
        end
        check(ptr_out == exp_r, req, "ptr_out", ptr_out, exp_r);
        check(no_fit == exp_nf, req, "no_fit", 36'(no_fit), 36'(exp_nf));
        check(bad_code == exp_bd, req, "bad_code", 36'(bad_code), 36'(exp_bd));
        @(negedge clk);
        check(done == 1'b0, "R10", "done one cycle", 36'(done), 36'd0);
        check(ptr_out == exp_r, "R10", "result held", ptr_out, exp_r);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R10", "reset done", 36'(done), 36'd0);
        check(ptr_out == '0, "R10", "reset ptr_out", ptr_out, 36'd0);
        check(no_fit == 1'b0 && bad_code == 1'b0, "R10", "reset flags",
              36'({no_fit, bad_code}), 36'd0);
    endtask

    task automatic t_local_forward();
        int lat;
        run_case(mk_local(36, 6, 5, 100), 36'd1, "R6", lat);
        run_case(mk_local(36, 7, 0, 100), 36'd1, "R6", lat);
        run_case(mk_local(30, 6, 63, 7), 36'd5, "R1", lat);
        run_case(mk_local(28, 8, 0, 50), 36'd2, "R6", lat);
        run_case(mk_local(10, 7, 9, 50), 36'd1, "R6", lat);
        run_case(mk_local(30, 6, 0, 100), 36'd1000, "R4", lat);
        run_case(mk_local(36, 36, 0, 4), 36'd3, "R2", lat);
    endtask

    task automatic t_local_negative();
        int lat;
        run_case(mk_local(30, 6, 0, 100), -36'sd1, "R5", lat);
        run_case(mk_local(30, 6, 0, 100), -36'sd6, "R5", lat);
        run_case(mk_local(30, 6, 0, 100), -36'sd13, "R5", lat);
        run_case(mk_local(10, 7, 0, 100), -36'sd9, "R5", lat);
    endtask

    task automatic t_local_wrap();
        int lat;
        run_case(mk_local(30, 6, 0, 18'h3FFFF), 36'd6, "R4", lat);
        run_case(mk_local(30, 6, 0, 0), -36'sd1, "R4", lat);
    endtask

    task automatic t_zero_size();
        int lat;
        run_case(mk_local(20, 0, 3, 77), 36'd5, "R3", lat);
    endtask

    task automatic t_no_fit();
        int lat;
        run_case(mk_local(0, 37, 1, 200), 36'd1, "R2", lat);
        run_case(mk_local(20, 40, 0, 9), -36'sd4, "R2", lat);
    endtask

    task automatic t_compact();
        int lat;
        run_case(mk_comp(37, 1000), 36'd1, "R7", lat);
        run_case(mk_comp(43, 1000), 36'd1, "R7", lat);
        run_case(mk_comp(48, 1000), 36'd1, "R7", lat);
        run_case(mk_comp(50, 1000), 36'd7, "R7", lat);
        run_case(mk_comp(56, 1000), -36'sd1, "R7", lat);
        run_case(mk_comp(62, 1000), -36'sd3, "R7", lat);
        run_case(mk_comp(60, 5), 36'd4, "R7", lat);
        run_case(mk_comp(38, 30'h3FFFFFFF), 36'd6, "R4", lat);
        run_case(mk_comp(54, 0), -36'sd5, "R5", lat);
    endtask

    task automatic t_illegal();
        int lat;
        run_case(mk_comp(63, 1234), 36'd3, "R8", lat);
    endtask

    task automatic t_latency();
        int lat_small, lat_big;
        run_case(mk_local(30, 6, 0, 100), 36'd1, "R9", lat_small);
        run_case(mk_local(30, 6, 0, 100), 36'd6291457, "R9", lat_big);
        check(lat_big - lat_small == 29, "R9", "latency difference",
              36'(lat_big - lat_small), 36'd29);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_local_forward();
        t_local_negative();
        t_local_wrap();
        t_zero_size();
        t_no_fit();
        t_compact();
        t_illegal();
        t_latency();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule